// File: doc/BRIEF.md
# Linked Descriptor Fetch Engine

This block walks a linked list of transfer descriptors kept in memory. Software supplies a 64-bit head pointer as two 32-bit halves and pulses a start input. The engine then reads the first descriptor as a single six-beat burst on its own 64-bit read-only memory-mapped master port. It unpacks the beats into a segment record: destination and source addresses, row length, row count, the two strides, an identifier and a flag word. The record is offered to the transfer logic over a valid/ready handshake.

Once the transfer logic reports that the segment is finished, the engine raises a one-cycle interrupt request if that descriptor asked for one. It then either follows the descriptor's next pointer or, if the descriptor is marked as the end of the chain, goes back to idle. A read that returns an error response ends the chain with a one-cycle error pulse. The identifier of the descriptor in use is always visible. While descriptor mode is on, the engine also masks the channel's cyclic request.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset `busy`, `ar_valid`, `seg_valid`, `irq_req` and `chain_err` are 0, and `desc_id` reads 0.
- R2: Each descriptor fetch is one read request with `ar_len`=5, `ar_size`=3 and `ar_burst`=2'b01 (incrementing). The address is the descriptor address with bits [2:0] forced to 0. `ar_valid` and `ar_addr` hold until `ar_ready`.
- R3: A `start` pulse is acted on only when `mode_en` is 1 and the engine is idle. The first address is {`head_hi`,`head_lo`}. A start with `mode_en` at 0 issues no read and leaves `busy` at 0.
- R4: Beat 0 carries flags in [31:0] and id in [63:32]. Beat 1 is the destination address, beat 2 the source address and beat 3 the next pointer. Beat 4 carries y_len in [31:0] and x_len in [63:32]. Beat 5 carries the source stride in [31:0] and the destination stride in [63:32]. The `seg_*` outputs present these values.
- R5: `seg_valid` stays high with stable fields until `seg_ready` is seen. No new read is issued while a segment is being offered.
- R6: In the cycle after `seg_done` is sampled, `irq_req` is high for one cycle exactly when flags bit 1 of the current descriptor is set.
- R7: After `seg_done`, a descriptor with flags bit 0 clear causes a fetch from its next pointer. A descriptor with flags bit 0 set returns the engine to idle with no further read.
- R8: `desc_id` shows the id of the last accepted descriptor while `mode_en` is 1, and reads 0 while `mode_en` is 0.
- R9: `cyclic_out` follows `cyclic_in` when `mode_en` is 0 and is forced to 0 when `mode_en` is 1.
- R10: A read response other than OKAY (2'b00) on any beat of a fetch still lets the burst drain to its last beat. No segment is then offered, `chain_err` pulses for one cycle and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Descriptor mode enable |
| start | input | 1 | Begin walking the chain (pulse) |
| head_lo | input | 32 | Head pointer, low half |
| head_hi | input | 32 | Head pointer, high half |
| cyclic_in | input | 1 | Cyclic request from the channel settings |
| cyclic_out | output | 1 | Cyclic request after masking by descriptor mode |
| ar_addr | output | 64 | Read address |
| ar_len | output | 8 | Burst length minus one |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| r_data | input | 64 | Read data |
| r_resp | input | 2 | Read response |
| r_last | input | 1 | Last beat of burst |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| seg_valid | output | 1 | Segment record offered |
| seg_ready | input | 1 | Segment record accepted |
| seg_dst | output | 64 | Destination address |
| seg_src | output | 64 | Source address |
| seg_xlen | output | 32 | Row length field |
| seg_ylen | output | 32 | Row count field |
| seg_src_stride | output | 32 | Source stride |
| seg_dst_stride | output | 32 | Destination stride |
| seg_done | input | 1 | Segment transfer finished (pulse) |
| desc_id | output | 32 | Id of the descriptor in use |
| irq_req | output | 1 | Per-segment interrupt request (pulse) |
| chain_err | output | 1 | Chain aborted on a read error (pulse) |
| busy | output | 1 | Engine not idle |

## Verification
On every cycle the assertions check the handshake rules. A pending read request and an offered segment each stay stable until accepted. No read is issued while idle or while a segment is on offer. An interrupt request never appears without a completion in the previous cycle. An error pulse coincides with idle. Only the bench's scenarios can show the content-dependent behaviour. That covers correct unpacking of each beat into the segment fields, following next pointers across chains of different lengths and stopping at the marked descriptor, the address alignment, draining and aborting after an error beat, and the masking of the cyclic request and the id by descriptor mode.

// File: rtl/dfe_pkg.sv
// Shared types for the descriptor fetch engine.
// Assumes a 64-bit read port and a six-beat descriptor layout.
package dfe_pkg;
    localparam int ADDR_W     = 64;
    localparam int DATA_W     = 64;
    localparam int FIELD_W    = 32;
    localparam int DESC_BEATS = 6;
    localparam int IDX_W      = $clog2(DESC_BEATS);
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    typedef struct packed {
        logic [FIELD_W-1:0] flags;
        logic [FIELD_W-1:0] id;
        logic [ADDR_W-1:0]  dst;
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  next;
        logic [FIELD_W-1:0] ylen;
        logic [FIELD_W-1:0] xlen;
        logic [FIELD_W-1:0] sstride;
        logic [FIELD_W-1:0] dstride;
    } desc_t;

    typedef enum logic [1:0] {W_IDLE, W_FETCH, W_OFFER, W_RUN} walk_state_t;
    typedef enum logic [1:0] {F_IDLE, F_ADDR, F_DATA} fetch_state_t;
endpackage

// File: rtl/dfe_fetch.sv
// Read sequencer: issues one fixed-length burst per go pulse and
// streams the accepted beats with their index.
// Assumes the memory returns exactly DESC_BEATS beats ending with r_last.
module dfe_fetch
    import dfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    output logic              ar_valid,
    input  logic              ar_ready,
    input  logic [1:0]        r_resp,
    input  logic              r_last,
    input  logic              r_valid,
    output logic              r_ready,
    output logic              beat_we,
    output logic [IDX_W-1:0]  beat_idx,
    output logic              fin,
    output logic              fail
);
    fetch_state_t      ph_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic              bad_q;

    // Fixed burst attributes and channel handshakes
    assign ar_addr  = addr_q;
    assign ar_len   = 8'(DESC_BEATS - 1);
    assign ar_size  = 3'(ALIGN_BITS);
    assign ar_burst = 2'b01;
    assign ar_valid = (ph_q == F_ADDR);
    assign r_ready  = (ph_q == F_DATA);
    assign beat_we  = r_valid && r_ready;
    assign beat_idx = idx_q;
    assign fin      = beat_we && r_last;
    assign fail     = fin && (bad_q || (r_resp != 2'b00));

    // Phase, aligned address, beat index and sticky error tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= F_IDLE;
            addr_q <= '0;
            idx_q  <= '0;
            bad_q  <= 1'b0;
        end else begin
            case (ph_q)
                F_IDLE: if (go) begin
                    addr_q <= {go_addr[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                    ph_q   <= F_ADDR;
                end
                F_ADDR: if (ar_ready) begin
                    ph_q  <= F_DATA;
                    idx_q <= '0;
                    bad_q <= 1'b0;
                end
                F_DATA: if (beat_we) begin
                    idx_q <= idx_q + 1'b1;
                    bad_q <= bad_q || (r_resp != 2'b00);
                    if (r_last) ph_q <= F_IDLE;
                end
                default: ph_q <= F_IDLE;
            endcase
        end
    end

    p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));
endmodule

// File: rtl/dfe_unpack.sv
// Field bank: writes each accepted beat into the descriptor fields it carries.
// Assumes beats arrive in order with index 0..DESC_BEATS-1.
module dfe_unpack
    import dfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output desc_t             desc
);
    desc_t d_q;

    assign desc = d_q;

    // Beat-to-field placement, lower half holds the earlier field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else if (we) begin
            case (idx)
                3'd0: begin d_q.flags   <= data[31:0]; d_q.id      <= data[63:32]; end
                3'd1: d_q.dst  <= data;
                3'd2: d_q.src  <= data;
                3'd3: d_q.next <= data;
                3'd4: begin d_q.ylen    <= data[31:0]; d_q.xlen    <= data[63:32]; end
                3'd5: begin d_q.sstride <= data[31:0]; d_q.dstride <= data[63:32]; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/desc_chain_walker.sv
// Chain controller: starts at the head pointer, fetches and offers each
// descriptor, waits for its segment to finish, then follows or ends the chain.
// Assumes seg_done is pulsed once per accepted segment.
module desc_chain_walker
    import dfe_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_en,
    input  logic         start,
    input  logic [31:0]  head_lo,
    input  logic [31:0]  head_hi,
    input  logic         cyclic_in,
    output logic         cyclic_out,
    output logic [63:0]  ar_addr,
    output logic [7:0]   ar_len,
    output logic [2:0]   ar_size,
    output logic [1:0]   ar_burst,
    output logic         ar_valid,
    input  logic         ar_ready,
    input  logic [63:0]  r_data,
    input  logic [1:0]   r_resp,
    input  logic         r_last,
    input  logic         r_valid,
    output logic         r_ready,
    output logic         seg_valid,
    input  logic         seg_ready,
    output logic [63:0]  seg_dst,
    output logic [63:0]  seg_src,
    output logic [31:0]  seg_xlen,
    output logic [31:0]  seg_ylen,
    output logic [31:0]  seg_src_stride,
    output logic [31:0]  seg_dst_stride,
    input  logic         seg_done,
    output logic [31:0]  desc_id,
    output logic         irq_req,
    output logic         chain_err,
    output logic         busy
);
    localparam int FLAG_LAST = 0;
    localparam int FLAG_IRQ  = 1;

    walk_state_t        st_q;
    logic [FIELD_W-1:0] cur_id_q;
    logic               irq_q;
    logic               err_q;
    logic               f_go;
    logic [ADDR_W-1:0]  f_addr;
    logic               beat_we;
    logic [IDX_W-1:0]   beat_idx;
    logic               fin;
    logic               fail;
    desc_t              d;

    dfe_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .go(f_go), .go_addr(f_addr),
        .ar_addr(ar_addr), .ar_len(ar_len), .ar_size(ar_size),
        .ar_burst(ar_burst), .ar_valid(ar_valid), .ar_ready(ar_ready),
        .r_resp(r_resp), .r_last(r_last), .r_valid(r_valid), .r_ready(r_ready),
        .beat_we(beat_we), .beat_idx(beat_idx), .fin(fin), .fail(fail)
    );

    dfe_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .we(beat_we), .idx(beat_idx),
        .data(r_data), .desc(d)
    );

    // Fetch launch: head pointer on start, next pointer after a non-final segment
    always_comb begin
        f_go   = 1'b0;
        f_addr = {head_hi, head_lo};
        if (st_q == W_IDLE) begin
            f_go = start && mode_en;
        end else if (st_q == W_RUN) begin
            f_go   = seg_done && !d.flags[FLAG_LAST];
            f_addr = d.next;
        end
    end

    // Walk sequencing, id capture and one-cycle event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= W_IDLE;
            cur_id_q <= '0;
            irq_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
            case (st_q)
                W_IDLE:  if (f_go) st_q <= W_FETCH;
                W_FETCH: if (fin) begin
                    if (fail) begin
                        st_q  <= W_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        st_q <= W_OFFER;
                    end
                end
                W_OFFER: if (seg_ready) begin
                    st_q     <= W_RUN;
                    cur_id_q <= d.id;
                end
                W_RUN: if (seg_done) begin
                    irq_q <= d.flags[FLAG_IRQ];
                    st_q  <= d.flags[FLAG_LAST] ? W_IDLE : W_FETCH;
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    // Segment record and status outputs
    assign seg_valid      = (st_q == W_OFFER);
    assign seg_dst        = d.dst;
    assign seg_src        = d.src;
    assign seg_xlen       = d.xlen;
    assign seg_ylen       = d.ylen;
    assign seg_src_stride = d.sstride;
    assign seg_dst_stride = d.dstride;
    assign desc_id        = mode_en ? cur_id_q : '0;
    assign irq_req        = irq_q;
    assign chain_err      = err_q;
    assign busy           = (st_q != W_IDLE);
    assign cyclic_out     = cyclic_in && !mode_en;

    p_offer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_ready |=> seg_valid && $stable(seg_dst) && $stable(seg_xlen));
    p_no_fetch_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !ar_valid);
    p_read_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> busy);
    p_irq_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(seg_done));
    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |-> !busy && !seg_valid);
endmodule

// File: tb/sim_desc_chain_walker.sv
module sim_desc_chain_walker;
    localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;
    localparam int NVEC = 4;
    // {first descriptor index, descriptors in chain}
    localparam int VEC [NVEC][2] = '{'{0, 3}, '{3, 1}, '{4, 3}, '{1, 2}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, start = 1'b0, cyclic_in = 1'b0;
    logic [31:0] head_lo = '0, head_hi = '0;
    logic ar_ready = 1'b0, r_last = 1'b0, r_valid = 1'b0;
    logic [63:0] r_data = '0;
    logic [1:0] r_resp = '0;
    logic seg_ready = 1'b0, seg_done = 1'b0;
    logic cyclic_out, ar_valid, r_ready, seg_valid, irq_req, chain_err, busy;
    logic [63:0] ar_addr, seg_dst, seg_src;
    logic [7:0] ar_len;
    logic [2:0] ar_size;
    logic [1:0] ar_burst;
    logic [31:0] seg_xlen, seg_ylen, seg_src_stride, seg_dst_stride, desc_id;

    int checks = 0, fails = 0;
    int err_beat = -1;
    logic [63:0] exp_ar = '0;

    always #2 clk = ~clk;

    desc_chain_walker u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] flags_of(input int k);
        return {30'd0, k[0], (k == 2 || k == 3 || k == 6)};
    endfunction

    function automatic logic [63:0] beat_of(input int k, input int b);
        case (b)
            0: return {32'h100 + 32'(k), flags_of(k)};
            1: return {32'hD5D5_0000 + 32'(k), 32'h1000 * 32'(k + 1)};
            2: return {32'h5A5A_0000 + 32'(k), 32'h2000 * 32'(k + 1)};
            3: return BASE + 64'(k + 1) * 64;
            4: return {32'(k * 16 + 15), 32'(k)};
            default: return {32'h200 + 32'(k), 32'h100 + 32'(k)};
        endcase
    endfunction

    // Memory model: answers each read request with six beats
    initial begin
        forever begin
            @(negedge clk);
            if (ar_valid) begin
                chk("R2 ar_addr", ar_addr, exp_ar);
                chk("R2 burst attrs", {ar_len, ar_size, ar_burst}, {8'd5, 3'd3, 2'b01});
                ar_ready = 1'b1;
                @(negedge clk);
                ar_ready = 1'b0;
                for (int b = 0; b < 6; b++) begin
                    r_valid = 1'b1;
                    r_data  = beat_of(int'((ar_addr - BASE) >> 6), b);
                    r_resp  = (b == err_beat) ? 2'b10 : 2'b00;
                    r_last  = (b == 5);
                    @(negedge clk);
                end
                r_valid = 1'b0;
                r_last  = 1'b0;
                r_resp  = 2'b00;
            end
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_chain(input logic [63:0] head, input int k0, input int n);
        bit seen;
        head_lo = head[31:0];
        head_hi = head[63:32];
        exp_ar  = BASE + 64'(k0) * 64;
        pulse_start();
        for (int s = 0; s < n; s++) begin
            int k = k0 + s;
            seen = 0;
            for (int t = 0; t < 100 && !seen; t++) begin
                if (seg_valid) seen = 1; else @(negedge clk);
            end
            chk("R7 segment offered", 64'(seen), 64'd1);
            chk("R4 dst", seg_dst, beat_of(k, 1));
            chk("R4 src", seg_src, beat_of(k, 2));
            chk("R4 ylen/xlen", {seg_xlen, seg_ylen}, beat_of(k, 4));
            chk("R4 strides", {seg_dst_stride, seg_src_stride}, beat_of(k, 5));
            @(negedge clk);
            chk("R5 held while not ready", {63'd0, seg_valid}, 64'd1);
            chk("R5 dst stable", seg_dst, beat_of(k, 1));
            seg_ready = 1'b1;
            @(negedge clk);
            seg_ready = 1'b0;
            chk("R8 desc_id", 64'(desc_id), 64'h100 + 64'(k));
            chk("R5 offer dropped", {63'd0, seg_valid}, 64'd0);
            exp_ar = BASE + 64'(k + 1) * 64;
            seg_done = 1'b1;
            @(negedge clk);
            seg_done = 1'b0;
            chk("R6 irq_req", 64'(irq_req), 64'(k % 2));
            @(negedge clk);
            chk("R6 irq one cycle", 64'(irq_req), 64'd0);
        end
        repeat (4) @(negedge clk);
        chk("R7 idle after last", {62'd0, busy, ar_valid}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit eseen;
        bit oseen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {59'd0, busy, ar_valid, seg_valid, irq_req, chain_err}, 64'd0);
        chk("R1 reset id", 64'(desc_id), 64'd0);

        // R3: start ignored with mode off
        head_lo = BASE[31:0];
        head_hi = BASE[63:32];
        pulse_start();
        repeat (4) @(negedge clk);
        chk("R3 start ignored when mode off", {62'd0, busy, ar_valid}, 64'd0);

        mode_en = 1'b1;
        for (int v = 0; v < NVEC; v++)
            run_chain(BASE + 64'(VEC[v][0]) * 64, VEC[v][0], VEC[v][1]);

        // R2: misaligned head pointer is aligned on the bus
        run_chain(BASE + 3 * 64 + 5, 3, 1);

        // R8: id hidden when mode off; R9: cyclic masking
        chk("R8 id while on", 64'(desc_id), 64'h103);
        cyclic_in = 1'b1;
        @(negedge clk);
        chk("R9 cyclic masked when on", 64'(cyclic_out), 64'd0);
        mode_en = 1'b0;
        @(negedge clk);
        chk("R8 id zero when off", 64'(desc_id), 64'd0);
        chk("R9 cyclic passes when off", 64'(cyclic_out), 64'd1);
        mode_en = 1'b1;
        cyclic_in = 1'b0;

        // R10: error response on a middle beat
        err_beat = 2;
        head_lo = BASE[31:0];
        head_hi = BASE[63:32];
        exp_ar = BASE;
        pulse_start();
        eseen = 0;
        oseen = 0;
        for (int t = 0; t < 40; t++) begin
            if (chain_err) begin
                eseen = 1;
                chk("R10 idle at error", 64'(busy), 64'd0);
            end
            if (seg_valid) oseen = 1;
            @(negedge clk);
        end
        chk("R10 error pulse seen", 64'(eseen), 64'd1);
        chk("R10 no segment offered", 64'(oseen), 64'd0);
        chk("R10 idle after error", {62'd0, busy, ar_valid}, 64'd0);
        err_beat = -1;

        // R3/R4: engine restarts cleanly after error
        run_chain(BASE + 4 * 64, 4, 3);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule